// File: doc/BRIEF.md
# Carry-less Multiplier Unit

This block multiplies two XLEN-bit operands as polynomials over GF(2). Partial products are merged with exclusive-OR, so no carries propagate between bit positions. The full product is 2·XLEN bits wide. A 2-bit function code picks which XLEN-bit slice of it is returned: the low half, the high half, or a slice shifted down by one bit ("reversed window").

The unit works iteratively and handles one multiplier bit per clock. A caller raises `start` with the operands and the function code. While the unit is idle, that request is taken and `busy` rises. Exactly XLEN cycles later `done` pulses for one cycle and `result` carries the chosen slice. `result` then holds that value until the next completion. The XLEN parameter may be 32 or 64.

Top module: `clmul_unit`

## Requirements
- R1: Function codes 2'b00 and 2'b11 return product bits XLEN-1..0, where the product is the XOR over every set bit i of `op_b` of `op_a` shifted left by i.
- R2: Function code 2'b01 returns product bits 2·XLEN-1..XLEN, and the most significant bit of that result is always zero.
- R3: Function code 2'b10 returns product bits 2·XLEN-2..XLEN-1.
- R4: For the same operands, the high result (code 2'b01) equals the reversed result (code 2'b10) shifted right by one bit.
- R5: `done` is high for exactly one cycle, in the XLEN-th cycle after the clock edge that accepted `start`.
- R6: A `start` seen while idle is accepted and `busy` rises at that edge. A `start` raised while `busy` is high is ignored and does not change the running operation's result.
- R7: Operands and function code are captured at the accepting edge. Changes to `op_a`, `op_b` or `func_sel` after that edge have no effect on the result.
- R8: Asynchronous active-low reset clears `busy`, `done` and `result`, including in the middle of an operation.
- R9: `result` holds its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new multiply; taken only when idle |
| func_sel | input | 2 | Window select: 00/11 low, 01 high, 10 reversed |
| op_a | input | XLEN | Multiplicand |
| op_b | input | XLEN | Multiplier; one bit consumed per cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Selected product window, held until the next completion |

## Verification
The hardest case to reach from the ports is a new request arriving during an operation while the operand and function inputs are already changing. Only the captured copies may reach the accumulator. To get there, the stimulus keeps scrambling `op_a`, `op_b` and `func_sel` on every cycle after acceptance. It also pulses `start` with a different function code in the middle of the run. The result must still match the first request, and the completion must still fall exactly XLEN cycles after acceptance. The one-bit offset between the high and reversed windows is checked by running the same operand pair under both codes. The operand pairs are chosen to set the product's top bits.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

  typedef enum logic [1:0] {
    FN_LOW  = 2'b00,
    FN_HIGH = 2'b01,
    FN_REV  = 2'b10,
    FN_ALT  = 2'b11
  } clmul_fn_e;

endpackage

// File: rtl/clmul_ctrl.sv
module clmul_ctrl #(
  parameter int XLEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(XLEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XLEN - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q && (cnt_q == CNT_LAST);
  assign cnt_en = load_o || busy_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last_o) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q)); // R6
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_i)); // R6

endmodule

// File: rtl/clmul_datapath.sv
module clmul_datapath
  import clmul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [1:0]        func_i,
  input  logic [XLEN-1:0]   op_a_i,
  input  logic [XLEN-1:0]   op_b_i,
  output logic [2*XLEN-1:0] prod_nxt_o,
  output clmul_fn_e         func_o
);

  localparam int PW = 2 * XLEN;

  logic [PW-1:0]   acc_q, acc_d;
  logic [PW-1:0]   mcand_q, mcand_d;
  logic [XLEN-1:0] mplier_q, mplier_d;
  clmul_fn_e       func_q, func_d;
  logic            reg_en;
  logic [PW-1:0]   partial;

  assign reg_en  = load_i || step_i;
  assign partial = mplier_q[0] ? mcand_q : '0;

  always_comb begin
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    func_d   = func_q;
    if (load_i) begin
      acc_d    = '0;
      mcand_d  = {{XLEN{1'b0}}, op_a_i};
      mplier_d = op_b_i;
      func_d   = clmul_fn_e'(func_i);
    end else if (step_i) begin
      acc_d    = acc_q ^ partial;
      mcand_d  = {mcand_q[PW-2:0], 1'b0};
      mplier_d = {1'b0, mplier_q[XLEN-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      func_q   <= FN_LOW;
    end else if (reg_en) begin
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      func_q   <= func_d;
    end
  end

  assign prod_nxt_o = acc_q ^ partial;
  assign func_o     = func_q;

  AST_FUNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> $stable(func_q)); // R7

endmodule

// File: rtl/clmul_window.sv
module clmul_window
  import clmul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0] prod_i,
  input  clmul_fn_e         func_i,
  output logic [XLEN-1:0]   win_o
);

  localparam int PW = 2 * XLEN;

  always_comb begin
    unique case (func_i)
      FN_HIGH: win_o = prod_i[PW-1 -: XLEN];
      FN_REV:  win_o = prod_i[PW-2 -: XLEN];
      default: win_o = prod_i[XLEN-1:0];
    endcase
  end

endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
  import clmul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      func_sel,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);

  logic              load, step, last;
  logic [2*XLEN-1:0] prod_nxt;
  clmul_fn_e         func_q;
  logic [XLEN-1:0]   win;
  logic [XLEN-1:0]   result_q;

  clmul_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy),
    .done_o  (done)
  );

  clmul_datapath #(.XLEN(XLEN)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .step_i     (step),
    .func_i     (func_sel),
    .op_a_i     (op_a),
    .op_b_i     (op_b),
    .prod_nxt_o (prod_nxt),
    .func_o     (func_q)
  );

  clmul_window #(.XLEN(XLEN)) u_win (
    .prod_i (prod_nxt),
    .func_i (func_q),
    .win_o  (win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (last) begin
      result_q <= win;
    end
  end

  assign result = result_q;

  AST_HIGH_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && func_q == FN_HIGH) |-> !result[XLEN-1]); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!busy && !done && result == '0)); // R8

endmodule

// File: tb/test_clmul_unit.sv
module test_clmul_unit;

  localparam int XLEN = 64;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic [1:0]      func_sel;
  logic [XLEN-1:0] op_a;
  logic [XLEN-1:0] op_b;
  logic            busy;
  logic            done;
  logic [XLEN-1:0] result;

  int n_chk;
  int n_bad;

  clmul_unit #(.XLEN(XLEN)) i_clmul_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .func_sel (func_sel),
    .op_a     (op_a),
    .op_b     (op_b),
    .busy     (busy),
    .done     (done),
    .result   (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [2*XLEN-1:0] ref_prod(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    logic [2*XLEN-1:0] p;
    p = '0;
    for (int i = 0; i < XLEN; i++)
      if (b[i]) p = p ^ ({{XLEN{1'b0}}, a} << i);
    return p;
  endfunction

  function automatic logic [XLEN-1:0] ref_win(logic [XLEN-1:0] a, logic [XLEN-1:0] b, logic [1:0] f);
    logic [2*XLEN-1:0] p;
    p = ref_prod(a, b);
    case (f)
      2'b01:   return p[2*XLEN-1 -: XLEN];
      2'b10:   return p[2*XLEN-2 -: XLEN];
      default: return p[XLEN-1:0];
    endcase
  endfunction

  function automatic logic [XLEN-1:0] rnd();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Runs one operation; returns the result seen with done. Samples at negedges.
  task automatic run_op(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                        input logic [1:0] f, input bit scramble, input bit intrude,
                        output logic [XLEN-1:0] res);
    int n;
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; func_sel = f;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    chk("R6 busy after accept", XLEN'(busy), XLEN'(1));
    while (!done && n < 4 * XLEN) begin
      if (scramble) begin
        op_a = rnd(); op_b = rnd(); func_sel = 2'(~f);
      end
      start = intrude && (n == 5 || n == 6);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    // accept edge, then XLEN edges; done first visible at negedge XLEN+1
    chk("R5 latency", XLEN'(n), XLEN'(XLEN + 1));
    res = result;
    @(negedge clk);
    chk("R5 done one cycle", XLEN'(done), XLEN'(0));
    chk("R9 result held after done", result, res);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; func_sel = 2'b00; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    chk("R8 busy in reset", XLEN'(busy), XLEN'(0));
    chk("R8 done in reset", XLEN'(done), XLEN'(0));
    chk("R8 result in reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_directed();
    logic [XLEN-1:0] r;
    run_op(64'h5, 64'h3, 2'b00, 0, 0, r);
    chk("R1 0x5*0x3", r, 64'hF);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'b00, 0, 0, r);
    chk("R1 times one", r, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b01, 0, 0, r);
    chk("R2 top bits", r, 64'h4000_0000_0000_0000);
    run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b10, 0, 0, r);
    chk("R3 top bits", r, 64'h8000_0000_0000_0000);
    run_op(64'h1234_5678_9ABC_DEF0, 64'h0, 2'b10, 0, 0, r);
    chk("R3 zero multiplier", r, '0);
    run_op(64'hDEAD_BEEF_0BAD_F00D, 64'hC0FF_EE00_1234_5678, 2'b11, 0, 0, r);
    chk("R1 code 3 is low", r, ref_win(64'hDEAD_BEEF_0BAD_F00D, 64'hC0FF_EE00_1234_5678, 2'b00));
  endtask

  task automatic t_random();
    logic [XLEN-1:0] a, b, r;
    for (int k = 0; k < 8; k++) begin
      a = rnd(); b = rnd();
      run_op(a, b, 2'b00, 0, 0, r); chk("R1 random low", r, ref_win(a, b, 2'b00));
      run_op(a, b, 2'b01, 0, 0, r); chk("R2 random high", r, ref_win(a, b, 2'b01));
      chk("R2 high msb zero", XLEN'(r[XLEN-1]), XLEN'(0));
      run_op(a, b, 2'b10, 0, 0, r); chk("R3 random rev", r, ref_win(a, b, 2'b10));
    end
  endtask

  task automatic t_identity();
    logic [XLEN-1:0] a, b, rh, rr;
    for (int k = 0; k < 4; k++) begin
      a = rnd() | 64'hC000_0000_0000_0000;
      b = rnd() | 64'hC000_0000_0000_0000;
      run_op(a, b, 2'b01, 0, 0, rh);
      run_op(a, b, 2'b10, 0, 0, rr);
      chk("R4 high equals rev>>1", rh, rr >> 1);
    end
  endtask

  task automatic t_capture_and_intrude();
    logic [XLEN-1:0] a, b, r;
    a = rnd(); b = rnd();
    run_op(a, b, 2'b01, 1, 0, r);
    chk("R7 inputs changed after accept", r, ref_win(a, b, 2'b01));
    a = rnd(); b = rnd();
    run_op(a, b, 2'b10, 1, 1, r);
    chk("R6 start while busy ignored", r, ref_win(a, b, 2'b10));
  endtask

  task automatic t_hold();
    logic [XLEN-1:0] r;
    run_op(64'h0F0F, 64'h0101, 2'b00, 0, 0, r);
    op_a = rnd(); op_b = rnd(); func_sel = 2'b01;
    repeat (5) @(negedge clk);
    chk("R9 result held while idle", result, r);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    start = 1'b1; op_a = rnd(); op_b = rnd(); func_sel = 2'b00;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 busy cleared mid-op", XLEN'(busy), XLEN'(0));
    chk("R8 result cleared mid-op", result, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (XLEN + 3) @(negedge clk);
    chk("R8 no done after mid-op reset", XLEN'(done), XLEN'(0));
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_directed();
    t_random();
    t_identity();
    t_capture_and_intrude();
    t_hold();
    t_reset_mid();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule